// File: doc/BRIEF.md
# Command Packet Header Decoder

This block takes a stream of 32-bit command words, one per accepted handshake, and splits it into packets. Each packet opens with a header word whose top four bits select one of two formats: a register-write header, which names a starting register index and a payload count, or an opcode header, which names a 7-bit opcode and a payload count. Every header field has its own odd-parity check bit. Once a header is accepted, the block counts off the payload words that follow it.

Payload words of a register-write packet come out as write strobes. Their register index starts at the header's index and steps by one for each word. Payload words of an opcode packet come out tagged with the opcode, their position in the packet and a last-word marker. Headers of an unknown type set a sticky type-error flag. Headers that fail parity set a sticky parity-error flag. Neither kind produces any output. Executing opcodes, fetching the command ring and holding the register file belong to other blocks.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: The type code is header bits 31:28. `REGW_TYPE` (default 4'h4) selects register-write and `OPC_TYPE` (default 4'h7) selects opcode. Any other header word sets `err_type`, which stays set until reset. That word is dropped with no output, and the next word is read as a header.
- R2: A register-write header carries its count in bits 6:0, the count's check bit in bit 7, an 18-bit register index in bits 25:8, and the index's check bit in bit 27. Counts up to 127 are accepted.
- R3: An opcode header carries its count in bits 14:0, the count's check bit in bit 15, the opcode in bits 22:16, and the opcode's check bit in bit 23.
- R4: The check bit of a field is taken from the constant 16'h9669. It is the bit selected by the XOR of the eight nibbles of the zero-extended field, so the field and its check bit together hold an odd number of ones.
- R5: A header of either type with any failing check bit sets `err_parity`, which stays set until reset. That header and the following count words, as encoded in the header, produce no output at all.
- R6: Payload word k (from 0) of a register-write packet produces `wr_valid` in the cycle after it is accepted. It comes with `wr_index` = header index + k, wrapping in 18 bits, and with `wr_data` equal to the word.
- R7: An accepted opcode header produces `op_hdr_valid` in the cycle after it is accepted, with `op_code` and `op_count`. Payload word k then produces `op_valid` with `op_pos` = k, `op_data` equal to the word, and `op_last` set only for k = count-1.
- R8: A packet with count zero consumes only its header. The next accepted word is read as a header.
- R9: `in_ready` is high whenever reset is low. Words count only on cycles where `in_valid` is high, so idle cycles inside a packet change neither the positions nor the indices.
- R10: During and right after reset, all output strobes and both error flags are low, and the first accepted word is read as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register write strobe |
| wr_index | output | 18 | Register index of the write |
| wr_data | output | 32 | Value to write |
| op_hdr_valid | output | 1 | Opcode packet header accepted |
| op_code | output | 7 | Opcode of the current packet |
| op_count | output | 15 | Payload count of the current opcode packet |
| op_valid | output | 1 | Opcode payload word valid |
| op_pos | output | 15 | Position of the payload word in its packet |
| op_data | output | 32 | Opcode payload word |
| op_last | output | 1 | Final payload word of the packet |
| err_parity | output | 1 | Sticky header parity error |
| err_type | output | 1 | Sticky unknown header type error |

## Verification
Every output strobe is registered. A word accepted on a rising edge therefore shows its result, a write strobe or an opcode header or payload, right after that edge, and the error flags rise at the same moment. The driver changes inputs on falling edges and records each expected result in a queue as it sends the word. The monitor samples on the next falling edge, which is half a cycle after the result is due, and compares each strobe with the head of the queue. Any strobe that arrives while the queue is empty is a mismatch. That catches skipped packets that still leak output. The error flags are read after a short idle flush, when any change they should make has already happened.

// File: rtl/cmdhdr_pkg.sv
`timescale 1ns/1ps
package cmdhdr_pkg;

    localparam int WORD_W   = 32;
    localparam int TYPE_W   = 4;
    localparam int TYPE_LSB = 28;
    localparam int IDX_W    = 18;
    localparam int OPC_W    = 7;
    localparam int CNT_W    = 15;
    localparam int RCNT_W   = 7;
    localparam int NIBBLES  = WORD_W / 4;

    // Field placement: count/index of register-write, count/opcode of opcode header
    localparam int NFIELD = 4;
    localparam int FLD_LSB [NFIELD] = '{0, 8, 0, 16};
    localparam int FLD_W   [NFIELD] = '{RCNT_W, IDX_W, CNT_W, OPC_W};
    localparam int FLD_PAR [NFIELD] = '{7, 27, 15, 23};

    localparam logic [15:0] PAR_LUT = 16'h9669;

    typedef enum logic [1:0] {
        HK_REGW = 2'd0,
        HK_OPC  = 2'd1,
        HK_BAD  = 2'd2
    } hdr_kind_e;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_REGW = 2'd1,
        ST_OPC  = 2'd2,
        ST_SKIP = 2'd3
    } seq_state_e;

    typedef struct packed {
        hdr_kind_e          kind;
        logic               par_ok;
        logic [CNT_W-1:0]   count;
        logic [IDX_W-1:0]   index;
        logic [OPC_W-1:0]   opcode;
    } hdr_info_t;

    // Fold nibbles together, then pick the expected check bit out of the lookup constant
    function automatic logic odd_check_bit(input logic [WORD_W-1:0] v);
        logic [3:0] fold;
        fold = '0;
        for (int n = 0; n < NIBBLES; n++) begin
            fold = fold ^ v[n*4 +: 4];
        end
        return PAR_LUT[fold];
    endfunction

endpackage

// File: rtl/cmdhdr_hdr_decode.sv
`timescale 1ns/1ps
module cmdhdr_hdr_decode
    import cmdhdr_pkg::*;
#(
    parameter logic [TYPE_W-1:0] REGW_TYPE = 4'h4,
    parameter logic [TYPE_W-1:0] OPC_TYPE  = 4'h7
) (
    input  logic [WORD_W-1:0] word,
    output hdr_info_t         info
);

    logic [NFIELD-1:0] fld_ok;
    logic [TYPE_W-1:0] tcode;
    logic              unused_bits;

    assign tcode       = word[TYPE_LSB +: TYPE_W];
    assign unused_bits = ^word[26:24];

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        logic [WORD_W-1:0] fval;
        assign fval      = WORD_W'(word[FLD_LSB[g] +: FLD_W[g]]);
        assign fld_ok[g] = (odd_check_bit(fval) == word[FLD_PAR[g]]);
    end

    always_comb begin
        info        = '0;
        info.index  = word[8 +: IDX_W];
        info.opcode = word[16 +: OPC_W];
        if (tcode == REGW_TYPE) begin
            info.kind   = HK_REGW;
            info.count  = CNT_W'(word[RCNT_W-1:0]);
            info.par_ok = fld_ok[0] & fld_ok[1];
        end else if (tcode == OPC_TYPE) begin
            info.kind   = HK_OPC;
            info.count  = word[CNT_W-1:0];
            info.par_ok = fld_ok[2] & fld_ok[3];
        end else begin
            info.kind   = HK_BAD;
            info.count  = '0;
            info.par_ok = 1'b0;
        end
    end

endmodule

// File: rtl/cmdhdr_seq.sv
`timescale 1ns/1ps
module cmdhdr_seq
    import cmdhdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [WORD_W-1:0] word,
    input  hdr_info_t         info,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_index,
    output logic [WORD_W-1:0] wr_data,
    output logic              op_hdr_valid,
    output logic [OPC_W-1:0]  op_code,
    output logic [CNT_W-1:0]  op_count,
    output logic              op_valid,
    output logic [CNT_W-1:0]  op_pos,
    output logic [WORD_W-1:0] op_data,
    output logic              op_last,
    output logic              err_parity,
    output logic              err_type
);

    seq_state_e       state;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] offs;
    logic [IDX_W-1:0] base_idx;
    logic             last_word;

    assign last_word = (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HDR;
            remain       <= '0;
            offs         <= '0;
            base_idx     <= '0;
            wr_valid     <= 1'b0;
            wr_index     <= '0;
            wr_data      <= '0;
            op_hdr_valid <= 1'b0;
            op_code      <= '0;
            op_count     <= '0;
            op_valid     <= 1'b0;
            op_pos       <= '0;
            op_data      <= '0;
            op_last      <= 1'b0;
            err_parity   <= 1'b0;
            err_type     <= 1'b0;
        end else begin
            wr_valid     <= 1'b0;
            op_valid     <= 1'b0;
            op_hdr_valid <= 1'b0;
            if (acc) begin
                unique case (state)
                    ST_HDR: begin
                        remain <= info.count;
                        offs   <= '0;
                        if (info.kind == HK_BAD) begin
                            err_type <= 1'b1;
                        end else if (!info.par_ok) begin
                            err_parity <= 1'b1;
                            if (info.count != '0) state <= ST_SKIP;
                        end else if (info.kind == HK_REGW) begin
                            base_idx <= info.index;
                            if (info.count != '0) state <= ST_REGW;
                        end else begin
                            op_hdr_valid <= 1'b1;
                            op_code      <= info.opcode;
                            op_count     <= info.count;
                            if (info.count != '0) state <= ST_OPC;
                        end
                    end
                    ST_REGW: begin
                        wr_valid <= 1'b1;
                        wr_index <= base_idx + IDX_W'(offs);
                        wr_data  <= word;
                        offs     <= offs + CNT_W'(1);
                        remain   <= remain - CNT_W'(1);
                        if (last_word) state <= ST_HDR;
                    end
                    ST_OPC: begin
                        op_valid <= 1'b1;
                        op_pos   <= offs;
                        op_data  <= word;
                        op_last  <= last_word;
                        offs     <= offs + CNT_W'(1);
                        remain   <= remain - CNT_W'(1);
                        if (last_word) state <= ST_HDR;
                    end
                    default: begin
                        remain <= remain - CNT_W'(1);
                        if (last_word) state <= ST_HDR;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cmd_hdr_decoder.sv
`timescale 1ns/1ps
module cmd_hdr_decoder
    import cmdhdr_pkg::*;
#(
    parameter logic [TYPE_W-1:0] REGW_TYPE = 4'h4,
    parameter logic [TYPE_W-1:0] OPC_TYPE  = 4'h7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_index,
    output logic [WORD_W-1:0] wr_data,
    output logic              op_hdr_valid,
    output logic [OPC_W-1:0]  op_code,
    output logic [CNT_W-1:0]  op_count,
    output logic              op_valid,
    output logic [CNT_W-1:0]  op_pos,
    output logic [WORD_W-1:0] op_data,
    output logic              op_last,
    output logic              err_parity,
    output logic              err_type
);

    hdr_info_t info;
    logic      acc;

    assign in_ready = ~rst;
    assign acc      = in_valid & in_ready;

    cmdhdr_hdr_decode #(
        .REGW_TYPE (REGW_TYPE),
        .OPC_TYPE  (OPC_TYPE)
    ) u_decode (
        .word (in_word),
        .info (info)
    );

    cmdhdr_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .word         (in_word),
        .info         (info),
        .wr_valid     (wr_valid),
        .wr_index     (wr_index),
        .wr_data      (wr_data),
        .op_hdr_valid (op_hdr_valid),
        .op_code      (op_code),
        .op_count     (op_count),
        .op_valid     (op_valid),
        .op_pos       (op_pos),
        .op_data      (op_data),
        .op_last      (op_last),
        .err_parity   (err_parity),
        .err_type     (err_type)
    );

endmodule

// File: rtl/cmd_hdr_decoder_chk.sv
`timescale 1ns/1ps
module cmd_hdr_decoder_chk
    import cmdhdr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             wr_valid,
    input logic [IDX_W-1:0] wr_index,
    input logic             op_hdr_valid,
    input logic [CNT_W-1:0] op_count,
    input logic             op_valid,
    input logic [CNT_W-1:0] op_pos,
    input logic             op_last,
    input logic             err_parity,
    input logic             err_type
);

    p_type_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        err_type |=> err_type);

    p_par_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_parity |=> err_parity);

    p_index_step_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(wr_valid)) |-> (wr_index == $past(wr_index) + IDX_W'(1)));

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, op_valid, op_hdr_valid}));

    p_pos_step_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && $past(op_valid)) |-> (op_pos == $past(op_pos) + CNT_W'(1)));

    p_first_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && $past(op_hdr_valid)) |-> (op_pos == '0));

    p_last_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_last) |-> (op_pos == op_count - CNT_W'(1)));

    p_needs_word_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid || op_valid || op_hdr_valid) |-> $past(in_valid));

endmodule

bind cmd_hdr_decoder cmd_hdr_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .wr_valid     (wr_valid),
    .wr_index     (wr_index),
    .op_hdr_valid (op_hdr_valid),
    .op_count     (op_count),
    .op_valid     (op_valid),
    .op_pos       (op_pos),
    .op_last      (op_last),
    .err_parity   (err_parity),
    .err_type     (err_type)
);

// File: tb/cmd_hdr_decoder_bench.sv
`timescale 1ns/1ps
module cmd_hdr_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid, op_hdr_valid, op_valid, op_last, err_parity, err_type;
    logic [17:0] wr_index;
    logic [31:0] wr_data, op_data;
    logic [6:0]  op_code;
    logic [14:0] op_count, op_pos;

    always #4 clk = ~clk;

    cmd_hdr_decoder u_cmd_hdr_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .wr_valid(wr_valid), .wr_index(wr_index), .wr_data(wr_data),
        .op_hdr_valid(op_hdr_valid), .op_code(op_code), .op_count(op_count),
        .op_valid(op_valid), .op_pos(op_pos), .op_data(op_data), .op_last(op_last),
        .err_parity(err_parity), .err_type(err_type)
    );

    typedef struct {
        int          kind;   // 0 write strobe, 1 opcode header, 2 opcode payload
        logic [31:0] f1;
        logic [31:0] f2;
        logic        last;
        string       req;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // odd parity: field plus check bit hold an odd number of ones
    function automatic logic pbit(input logic [31:0] v);
        return ($countones(v) % 2) == 0;
    endfunction

    function automatic logic [31:0] hdr_regw(input logic [17:0] idx, input logic [6:0] cnt);
        return {4'h4, pbit(32'(idx)), 1'b0, idx, pbit(32'(cnt)), cnt};
    endfunction

    function automatic logic [31:0] hdr_opc(input logic [6:0] op, input logic [14:0] cnt);
        return {4'h7, 4'h0, pbit(32'(op)), op, pbit(32'(cnt)), cnt};
    endfunction

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 32'hDEAD_BEEF;
        end
    endtask

    task automatic push(input int kind, input logic [31:0] f1, input logic [31:0] f2,
                        input logic last, input string req);
        exp_t e;
        e.kind = kind; e.f1 = f1; e.f2 = f2; e.last = last; e.req = req;
        expq.push_back(e);
    endtask

    task automatic send_regw(input logic [17:0] idx, input int cnt, input logic [31:0] seed,
                             input logic bad_cnt, input logic bad_idx, input int gap,
                             input string req);
        logic [31:0] h;
        h = hdr_regw(idx, 7'(cnt));
        h[7]  = h[7] ^ bad_cnt;
        h[27] = h[27] ^ bad_idx;
        put_word(h);
        if (gap > 0) idle(gap);
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] d;
            d = (bad_cnt | bad_idx) ? hdr_opc(7'h05, 15'd0) : seed + 32'(k) * 32'h0101_0101;
            if (!(bad_cnt | bad_idx)) push(0, 32'(18'(idx + 18'(k))), d, 1'b0, req);
            put_word(d);
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic send_opc(input logic [6:0] op, input int cnt, input logic [31:0] seed,
                            input logic bad_cnt, input logic bad_op, input string req);
        logic [31:0] h;
        h = hdr_opc(op, 15'(cnt));
        h[15] = h[15] ^ bad_cnt;
        h[23] = h[23] ^ bad_op;
        if (!(bad_cnt | bad_op)) push(1, 32'(op), 32'(cnt), 1'b0, req);
        put_word(h);
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] d;
            d = (bad_cnt | bad_op) ? hdr_regw(18'h1, 7'd0) : seed ^ 32'(k * 7);
            if (!(bad_cnt | bad_op)) push(2, 32'(k), d, (k == cnt - 1), req);
            put_word(d);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "wr_valid in reset", 32'(wr_valid), 0);
        check("R10", "op strobes in reset", 32'({op_valid, op_hdr_valid}), 0);
        check("R10", "error flags in reset", 32'({err_parity, err_type}), 0);
        check("R9", "in_ready in reset", 32'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "in_ready after reset", 32'(in_ready), 1);
        check("R10", "flags after reset", 32'({err_parity, err_type}), 0);
    endtask

    task automatic flush_check(input string req, input logic ep, input logic et);
        idle(3);
        check(req, "pending results", 32'(expq.size()), 0);
        check(req, "err_parity", 32'(err_parity), 32'(ep));
        check(req, "err_type", 32'(err_type), 32'(et));
    endtask

    // monitor: registered outputs are due one edge after acceptance
    always @(negedge clk) begin
        if (!rst && (wr_valid || op_valid || op_hdr_valid)) begin
            if (expq.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R5 unexpected output: actual wr=%0d hdr=%0d op=%0d expected none",
                         wr_valid, op_hdr_valid, op_valid);
            end else begin
                exp_t e;
                int   got;
                e   = expq.pop_front();
                got = wr_valid ? 0 : (op_hdr_valid ? 1 : 2);
                check(e.req, "output kind", 32'(got), 32'(e.kind));
                if (got == e.kind) begin
                    if (got == 0) begin
                        check(e.req, "wr_index (R6)", 32'(wr_index), e.f1);
                        check(e.req, "wr_data (R6)", wr_data, e.f2);
                    end else if (got == 1) begin
                        check(e.req, "op_code (R7)", 32'(op_code), e.f1);
                        check(e.req, "op_count (R7)", 32'(op_count), e.f2);
                    end else begin
                        check(e.req, "op_pos (R7)", 32'(op_pos), e.f1);
                        check(e.req, "op_data (R7)", op_data, e.f2);
                        check(e.req, "op_last (R7)", 32'(op_last), 32'(e.last));
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2 R6: basic register-write packet
        send_regw(18'h00100, 3, 32'h1000_0000, 0, 0, 0, "R6");
        // R3 R7: opcode packet
        send_opc(7'h23, 2, 32'hA5A5_0000, 0, 0, "R7");
        // R8: zero-count write then zero-count opcode, then a one-word opcode packet
        send_regw(18'h00200, 0, 32'h0, 0, 0, 0, "R8");
        send_opc(7'h7F, 0, 32'h0, 0, 0, "R8");
        send_opc(7'h11, 1, 32'h5555_AAAA, 0, 0, "R8");
        // R9 R6: idle gaps inside a packet, index wraps past the top of 18 bits
        send_regw(18'h3FFFE, 4, 32'h2200_0000, 0, 0, 2, "R9");
        // R2: maximum count of 127
        send_regw(18'h01234, 127, 32'h3000_0000, 0, 0, 0, "R2");
        // R3 R4: wide opcode count beyond seven bits
        send_opc(7'h40, 300, 32'h0F0F_0000, 0, 0, "R3");
        flush_check("R4", 1'b0, 1'b0);

        // R1: unknown type words are dropped and flagged
        put_word(32'h1234_5678);
        put_word(32'h0000_0000);
        send_regw(18'h00055, 2, 32'h4400_0000, 0, 0, 0, "R1");
        flush_check("R1", 1'b0, 1'b1);

        // R5: index check bit flipped, payload skipped even though it looks like headers
        send_regw(18'h00300, 2, 32'h0, 0, 1, 0, "R5");
        send_opc(7'h09, 2, 32'h7777_0000, 0, 0, "R5");
        flush_check("R5", 1'b1, 1'b1);

        do_reset();
        // R5: count check bit flipped on an opcode header
        send_opc(7'h31, 1, 32'h0, 1, 0, "R5");
        flush_check("R5", 1'b1, 1'b0);
        // R5: opcode check bit flipped, then register-write count check bit flipped
        send_opc(7'h0C, 3, 32'h0, 0, 1, "R5");
        send_regw(18'h00400, 2, 32'h0, 1, 0, 0, "R5");
        send_regw(18'h00401, 1, 32'h6600_0000, 0, 0, 0, "R5");
        flush_check("R5", 1'b1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule